// File: doc/BRIEF.md
# Command-Tagged SPI Master Engine

This block is a master-mode SPI transfer engine. Software, or a neighbouring controller, pushes command words into a four-entry transmit queue. Each word carries a data frame, a one-hot pattern naming the select line to drive, and a flag that keeps that line asserted into the following frame. The engine takes commands one at a time and shifts each frame out on `sck`/`mosi` while it samples `miso`. Every frame it sends places exactly one received word into a four-entry receive queue.

The bit rate comes from an external `tick` strobe. Every tick is one half of an SCK period. The mode inputs set the clock idle level, the sampling edge, the shift order, the frame length (1 to 16 bits) and the idle level of each select line. A halt input stops the engine from starting new frames. Each queue has its own flush input. Both queues report their fill level. A receive word that arrives while the receive queue is full is lost, and that loss is recorded in a sticky flag.

Top module: `spi_cmd_master`

## Requirements
- R1: The transmit queue holds at most 4 commands, and `tx_fill` reports how many it holds. A push while `tx_fill` is 4 is ignored and leaves the queue unchanged.
- R2: A frame has `cfg_frame_len_m1`+1 bits. The engine produces exactly twice that many `sck` transitions per frame and ignores data bits above the frame length.
- R3: With `cfg_lsb_first`=0 the frame goes out on `mosi` starting at bit `cfg_frame_len_m1` and ending at bit 0. With `cfg_lsb_first`=1 it goes out starting at bit 0.
- R4: While no select line is active, `sck` equals `cfg_cpol`. With `cfg_cpha`=0 data is sampled on the first transition of each bit (the one away from the idle level). With `cfg_cpha`=1 it is sampled on the second.
- R5: A select line that is not active drives the level of its bit in `cfg_cs_idle`. The line named by the command drives the inverse of that bit while it is active, and at most one line is active at any time.
- R6: When `tx_keep_sel`=1 in a command, its select line stays active from the end of that frame until the next frame begins. When the flag is 0, the line is released after the frame.
- R7: A select line becomes active one tick before the first `sck` transition and is released one tick after the last one. `sck` and `cs_out` never change in the same cycle.
- R8: While `halt`=1 no new frame starts. `running` is 1 in the cycle after a cycle in which `halt` was 0, and 0 after a cycle in which `halt` was 1.
- R9: Each completed frame pushes one word into the receive queue. The sampled bits are placed right-aligned and put back into the shift order, with the upper bits set to 0. `rx_data` shows the oldest word, `rx_pop` removes it, and `rx_fill` reports the count.
- R10: The receive queue holds 4 words. A frame that completes while it is full is dropped and sets `rx_overflow`, which stays at 1 until a receive flush.
- R11: `flush_tx` empties the transmit queue in the next cycle. `flush_rx` empties the receive queue and clears `rx_overflow` in the next cycle. A flush takes priority over a push in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Half-SCK-period strobe |
| halt | input | 1 | Freeze: no new frames start |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on first transition, 1: on second |
| cfg_lsb_first | input | 1 | Shift order select |
| cfg_frame_len_m1 | input | 4 | Frame length minus one |
| cfg_cs_idle | input | NCS | Idle level per select line |
| flush_tx | input | 1 | Empty the transmit queue |
| flush_rx | input | 1 | Empty the receive queue, clear overflow |
| tx_push | input | 1 | Write one command |
| tx_data | input | 16 | Command data frame |
| tx_keep_sel | input | 1 | Keep select active after this frame |
| tx_sel | input | NCS | One-hot select line for this frame |
| tx_fill | output | 3 | Commands held |
| rx_pop | input | 1 | Remove oldest received word |
| rx_data | output | 16 | Oldest received word |
| rx_fill | output | 3 | Received words held |
| rx_overflow | output | 1 | Sticky receive-drop flag |
| running | output | 1 | Engine not halted |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | NCS | Select lines |

## Verification
The bench uses the default parameters: six select lines, queues four deep, 16-bit data. With these values both queues can be filled to their limits within a few dozen frames, so the dropped push and the dropped receive word are both reached. A tick on every second clock keeps each half SCK period two cycles long, which lets the one-tick lead and lag of the select line be measured in exact clock counts. The bench loops `mosi` back to `miso`, or forces `miso` high, across all four clock modes, both shift orders and frame lengths of 4, 8, 12 and 16 bits.

// File: rtl/spi_cmd_pkg.sv
// Package: shared constants and types for the command-tagged SPI master.
// Assumes a 16-bit maximum frame; the engine state encoding lives here.
package spi_cmd_pkg;

    localparam int DATA_W = 16;
    localparam int LEN_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } eng_state_t;

endpackage

// File: rtl/spi_cmd_fifo.sv
// Module: synchronous show-ahead queue with a fill counter and flush.
// Assumes DEPTH is a power of two. A push while full and a pop while
// empty are ignored. Flush takes priority over push and pop.
module spi_cmd_fifo #(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 4,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [WIDTH-1:0]  din,
    input  logic              pop,
    output logic [WIDTH-1:0]  dout,
    output logic              empty,
    output logic [FILL_W-1:0] fill
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    // Qualify requests against the current fill level.
    always_comb begin
        do_push = push && (fill != FILL_W'(DEPTH)) && !flush;
        do_pop  = pop && (fill != '0) && !flush;
        empty   = (fill == '0);
        dout    = mem[rd_ptr];
    end

    // Storage write; the data array needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
// Module: serial shifter and select sequencer. It advances only on tick,
// one tick per half SCK period. It assumes the command source is
// show-ahead: cmd_* are valid whenever cmd_valid is set. A select line
// goes active one tick before the first edge, and is released one tick
// after the last edge unless the command asked to keep it.
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int NCS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              halt,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              cmd_valid,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_keep,
    input  logic [NCS-1:0]    cmd_sel,
    output logic              cmd_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_act
);
    localparam int CNT_W = $clog2(2 * DATA_W + 1);
    localparam int BIT_W = LEN_W + 1;

    eng_state_t        state;
    logic [CNT_W-1:0]  edge_cnt;
    logic [CNT_W-1:0]  next_edge;
    logic [CNT_W-1:0]  last_edge;
    logic [BIT_W-1:0]  frame_bits;
    logic [BIT_W-1:0]  pad_bits;
    logic              sck_q;
    logic              keep_q;
    logic [DATA_W-1:0] sh_tx;
    logic [DATA_W-1:0] sh_rx;
    logic              start_ok;
    logic              frame_done;
    logic              is_leading;
    logic              do_sample;
    logic              do_shift;
    logic [DATA_W-1:0] load_word;

    // Frame geometry, edge classification and start/finish conditions.
    always_comb begin
        frame_bits = {1'b0, len_m1} + 1'b1;
        pad_bits   = BIT_W'(DATA_W) - frame_bits;
        last_edge  = CNT_W'({frame_bits, 1'b0});
        next_edge  = edge_cnt + 1'b1;
        is_leading = next_edge[0];
        do_sample  = is_leading ^ cpha;
        do_shift   = !do_sample && (next_edge != CNT_W'(1)) && (next_edge != last_edge);
        start_ok   = tick && (state != ST_SHIFT) && cmd_valid && !halt;
        frame_done = tick && (state == ST_SHIFT) && (edge_cnt == last_edge);
        load_word  = lsb_first ? cmd_data : (cmd_data << pad_bits);
        cmd_pop    = start_ok;
        rx_push    = frame_done;
        rx_word    = lsb_first ? (sh_rx >> pad_bits)
                               : (sh_rx & ({DATA_W{1'b1}} >> pad_bits));
        sck        = (state == ST_SHIFT) ? sck_q : cpol;
        mosi       = lsb_first ? sh_tx[0] : sh_tx[DATA_W-1];
    end

    // Sequencer: start, edge stepping, shifting, sampling and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            edge_cnt <= '0;
            sck_q    <= 1'b0;
            keep_q   <= 1'b0;
            sh_tx    <= '0;
            sh_rx    <= '0;
            cs_act   <= '0;
        end else if (tick) begin
            case (state)
                ST_IDLE, ST_HOLD: begin
                    sck_q <= cpol;
                    if (start_ok) begin
                        state    <= ST_SHIFT;
                        cs_act   <= cmd_sel;
                        keep_q   <= cmd_keep;
                        sh_tx    <= load_word;
                        sh_rx    <= '0;
                        edge_cnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (frame_done) begin
                        state <= keep_q ? ST_HOLD : ST_IDLE;
                        if (!keep_q) cs_act <= '0;
                    end else begin
                        edge_cnt <= next_edge;
                        sck_q    <= ~sck_q;
                        if (do_sample) begin
                            sh_rx <= lsb_first ? {miso, sh_rx[DATA_W-1:1]}
                                               : {sh_rx[DATA_W-2:0], miso};
                        end
                        if (do_shift) begin
                            sh_tx <= lsb_first ? (sh_tx >> 1) : (sh_tx << 1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_cmd_master.sv
// Module: top of the command-tagged SPI master. It joins the transmit
// command queue, the shift engine and the receive queue. It applies the
// per-line idle polarity to the select outputs and keeps the sticky
// receive-drop flag. Assumes tx_sel is one-hot or zero.
module spi_cmd_master
    import spi_cmd_pkg::*;
#(
    parameter int NCS      = 6,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int FILL_W   = $clog2(((TX_DEPTH > RX_DEPTH) ? TX_DEPTH : RX_DEPTH) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              halt,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic [LEN_W-1:0]  cfg_frame_len_m1,
    input  logic [NCS-1:0]    cfg_cs_idle,
    input  logic              flush_tx,
    input  logic              flush_rx,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_keep_sel,
    input  logic [NCS-1:0]    tx_sel,
    output logic [FILL_W-1:0] tx_fill,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic [FILL_W-1:0] rx_fill,
    output logic              rx_overflow,
    output logic              running,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_out
);
    localparam int CMD_W = DATA_W + NCS + 1;

    logic [CMD_W-1:0]  cmd_in;
    logic [CMD_W-1:0]  cmd_head;
    logic              cmd_empty;
    logic              cmd_pop;
    logic              rx_push;
    logic [DATA_W-1:0] rx_word;
    logic              rx_empty;
    logic              rx_drop;
    logic [NCS-1:0]    cs_act;

    // Pack the command word: keep flag, select pattern, data.
    always_comb begin
        cmd_in  = {tx_keep_sel, tx_sel, tx_data};
        rx_drop = rx_push && !flush_rx && (rx_fill == FILL_W'(RX_DEPTH));
        cs_out  = cfg_cs_idle ^ cs_act;
    end

    spi_cmd_fifo #(
        .WIDTH (CMD_W),
        .DEPTH (TX_DEPTH),
        .FILL_W(FILL_W)
    ) u_txq (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(flush_tx),
        .push (tx_push),
        .din  (cmd_in),
        .pop  (cmd_pop),
        .dout (cmd_head),
        .empty(cmd_empty),
        .fill (tx_fill)
    );

    spi_cmd_engine #(
        .NCS(NCS)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .halt     (halt),
        .cpol     (cfg_cpol),
        .cpha     (cfg_cpha),
        .lsb_first(cfg_lsb_first),
        .len_m1   (cfg_frame_len_m1),
        .cmd_valid(!cmd_empty),
        .cmd_data (cmd_head[DATA_W-1:0]),
        .cmd_keep (cmd_head[CMD_W-1]),
        .cmd_sel  (cmd_head[DATA_W +: NCS]),
        .cmd_pop  (cmd_pop),
        .rx_push  (rx_push),
        .rx_word  (rx_word),
        .sck      (sck),
        .mosi     (mosi),
        .miso     (miso),
        .cs_act   (cs_act)
    );

    spi_cmd_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (RX_DEPTH),
        .FILL_W(FILL_W)
    ) u_rxq (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(flush_rx),
        .push (rx_push),
        .din  (rx_word),
        .pop  (rx_pop),
        .dout (rx_data),
        .empty(rx_empty),
        .fill (rx_fill)
    );

    // Sticky drop flag, cleared only by a receive flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_rx) begin
            rx_overflow <= 1'b0;
        end else if (rx_drop && !rx_empty) begin
            rx_overflow <= 1'b1;
        end
    end

    // Running status follows the halt input one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else begin
            running <= !halt;
        end
    end
endmodule

// File: rtl/spi_cmd_checker.sv
// Module: protocol checker for spi_cmd_master, attached with bind. It only
// observes the top-level ports and holds for any legal stimulus in which
// tx_sel is one-hot or zero.
module spi_cmd_checker #(
    parameter int NCS      = 6,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int FILL_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt,
    input logic              cfg_cpol,
    input logic [NCS-1:0]    cfg_cs_idle,
    input logic              flush_tx,
    input logic              flush_rx,
    input logic [FILL_W-1:0] tx_fill,
    input logic [FILL_W-1:0] rx_fill,
    input logic              rx_overflow,
    input logic              running,
    input logic              sck,
    input logic [NCS-1:0]    cs_out
);
    logic [NCS-1:0] active;
    assign active = cs_out ^ cfg_cs_idle;

    AST_TX_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fill <= FILL_W'(TX_DEPTH)); // R1
    AST_RX_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fill <= FILL_W'(RX_DEPTH)); // R10
    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> (sck == cfg_cpol)); // R4
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active)); // R5
    AST_CS_SCK_APART: assert property (@(posedge clk) disable iff (!rst_n)
        ((sck != $past(sck)) && (cfg_cpol == $past(cfg_cpol))
         && (cfg_cs_idle == $past(cfg_cs_idle))) |-> (cs_out == $past(cs_out))); // R7
    AST_HALT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && (active == '0)) |=> (active == '0)); // R8
    AST_RUNNING_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (running == !$past(halt))); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overflow && !flush_rx) |=> rx_overflow); // R10
    AST_FLUSH_TX: assert property (@(posedge clk) disable iff (!rst_n)
        flush_tx |=> (tx_fill == '0)); // R11
    AST_FLUSH_RX: assert property (@(posedge clk) disable iff (!rst_n)
        flush_rx |=> ((rx_fill == '0) && !rx_overflow)); // R11
endmodule

bind spi_cmd_master spi_cmd_checker #(
    .NCS     (NCS),
    .TX_DEPTH(TX_DEPTH),
    .RX_DEPTH(RX_DEPTH),
    .FILL_W  (FILL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt       (halt),
    .cfg_cpol   (cfg_cpol),
    .cfg_cs_idle(cfg_cs_idle),
    .flush_tx   (flush_tx),
    .flush_rx   (flush_rx),
    .tx_fill    (tx_fill),
    .rx_fill    (rx_fill),
    .rx_overflow(rx_overflow),
    .running    (running),
    .sck        (sck),
    .cs_out     (cs_out)
);

// File: tb/spi_cmd_master_tb.sv
// Bench: a vector table over modes and lengths, then directed tests for
// reset, queue limits, halt, continuous select and flushes. The serial
// side is observed by a monitor that samples mosi on the edge the mode
// defines. The monitor also times the select line against sck.
module spi_cmd_master_tb;
    localparam int NCS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick;
    logic        halt = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cfg_lsb_first = 1'b0;
    logic [3:0]  cfg_frame_len_m1 = 4'd7;
    logic [NCS-1:0] cfg_cs_idle = '1;
    logic        flush_tx = 1'b0;
    logic        flush_rx = 1'b0;
    logic        tx_push = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_keep_sel = 1'b0;
    logic [NCS-1:0] tx_sel = '0;
    logic [2:0]  tx_fill;
    logic        rx_pop = 1'b0;
    logic [15:0] rx_data;
    logic [2:0]  rx_fill;
    logic        rx_overflow;
    logic        running;
    logic        sck;
    logic        mosi;
    logic        miso;
    logic [NCS-1:0] cs_out;
    logic        miso_one = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Tick on every second clock: one half SCK period is two cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= ~tick;
    end

    assign miso = miso_one ? 1'b1 : mosi;

    spi_cmd_master #(.NCS(NCS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_frame_len_m1(cfg_frame_len_m1), .cfg_cs_idle(cfg_cs_idle),
        .flush_tx(flush_tx), .flush_rx(flush_rx),
        .tx_push(tx_push), .tx_data(tx_data), .tx_keep_sel(tx_keep_sel), .tx_sel(tx_sel),
        .tx_fill(tx_fill), .rx_pop(rx_pop), .rx_data(rx_data), .rx_fill(rx_fill),
        .rx_overflow(rx_overflow), .running(running),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_out(cs_out)
    );

    // Serial monitor, sampling away from the active edge.
    int          cyc = 0;
    logic        prev_sck = 1'b0;
    logic        prev_act = 1'b0;
    logic [31:0] mon_val = '0;
    int          mon_cnt = 0;
    int          release_cnt = 0;
    int          t_assert = 0, t_first = 0, t_last = 0, t_rel = 0;
    bit          first_seen = 1'b0;
    logic [NCS-1:0] cs_pat = '0;

    always @(negedge clk) begin
        logic act;
        act = |(cs_out ^ cfg_cs_idle);
        cyc++;
        if (rst_n) begin
            if (!prev_act && act) begin
                t_assert   = cyc;
                first_seen = 1'b0;
                cs_pat     = cs_out;
                mon_val    = '0;
                mon_cnt    = 0;
            end
            if (act && (sck != prev_sck)) begin
                if (!first_seen) begin
                    t_first    = cyc;
                    first_seen = 1'b1;
                end
                t_last = cyc;
                if ((prev_sck == cfg_cpol) ^ cfg_cpha) begin
                    mon_val = {mon_val[30:0], mosi};
                    mon_cnt++;
                end
            end
            if (prev_act && !act) begin
                release_cnt++;
                t_rel = cyc;
            end
        end
        prev_sck = sck;
        prev_act = act;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rev_bits(input logic [15:0] d, input int n);
        logic [15:0] r;
        r = '0;
        for (int i = 0; i < n; i++) r[i] = d[n-1-i];
        return r;
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic push(input logic [15:0] d, input logic keep, input logic [NCS-1:0] sel);
        tx_push = 1'b1; tx_data = d; tx_keep_sel = keep; tx_sel = sel;
        step();
        tx_push = 1'b0;
    endtask

    task automatic pop();
        rx_pop = 1'b1;
        step();
        rx_pop = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (rx_fill >= 3'(n)) break;
        end
        repeat (4) @(negedge clk);
        #1;
    endtask

    // Vector fields: {cpol, cpha, lsb_first, miso_one, len_m1[3:0], data[15:0]}
    localparam logic [23:0] VEC [7] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd7,  16'h00A5},
        {1'b1, 1'b0, 1'b0, 1'b0, 4'd7,  16'h003C},
        {1'b0, 1'b1, 1'b1, 1'b0, 4'd7,  16'h00B1},
        {1'b1, 1'b1, 1'b1, 1'b0, 4'd15, 16'hC3A5},
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd15, 16'h8001},
        {1'b0, 1'b1, 1'b0, 1'b1, 4'd11, 16'h0ABC},
        {1'b1, 1'b0, 1'b1, 1'b0, 4'd3,  16'hFFF6}
    };

    initial begin
        repeat (3) step();
        // Reset state
        check("R5 reset cs idle", 32'(cs_out), 32'(cfg_cs_idle));
        check("R4 reset sck idle", 32'(sck), 32'(cfg_cpol));
        check("R1 reset tx_fill", 32'(tx_fill), 0);
        check("R10 reset rx_fill/overflow", {rx_overflow, 29'(0), rx_fill}, 0);
        check("R8 reset running", 32'(running), 0);
        rst_n = 1'b1;
        repeat (2) step();
        check("R8 running after release", 32'(running), 1);

        // Table walk over modes, orders and lengths
        for (int i = 0; i < 7; i++) begin
            logic [23:0] v;
            int n;
            logic [15:0] mask;
            logic [15:0] exp_wire;
            logic [15:0] exp_rx;
            v = VEC[i];
            cfg_cpol = v[23]; cfg_cpha = v[22]; cfg_lsb_first = v[21];
            miso_one = v[20]; cfg_frame_len_m1 = v[19:16];
            repeat (3) step();
            n = int'(v[19:16]) + 1;
            mask = 16'hFFFF >> (16 - n);
            exp_wire = v[21] ? rev_bits(v[15:0], n) : (v[15:0] & mask);
            exp_rx = v[20] ? mask : (v[15:0] & mask);
            push(v[15:0], 1'b0, 6'b000001);
            wait_rx(1);
            check("R2 bit count", mon_cnt, 2 * 0 + n);
            check("R3 wire order", mon_val, 32'(exp_wire));
            check("R4 sck idle after frame", 32'(sck), 32'(cfg_cpol));
            check("R9 rx_fill", 32'(rx_fill), 1);
            check("R9 rx_data", 32'(rx_data), 32'(exp_rx));
            check("R7 lead one tick", t_first - t_assert, 2);
            check("R7 lag one tick", t_rel - t_last, 2);
            pop();
        end

        // Queue limits, halt, receive overflow
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0;
        cfg_frame_len_m1 = 4'd7; miso_one = 1'b0;
        halt = 1'b1;
        step();
        check("R8 running low under halt", 32'(running), 0);
        push(16'h11, 1'b0, 6'b000001);
        push(16'h22, 1'b0, 6'b000001);
        push(16'h33, 1'b0, 6'b000001);
        push(16'h44, 1'b0, 6'b000001);
        push(16'h55, 1'b0, 6'b000001);
        check("R1 tx_fill capped", 32'(tx_fill), 4);
        repeat (30) step();
        check("R8 no start while halted", 32'(cs_out), 32'(cfg_cs_idle));
        check("R8 no rx while halted", 32'(rx_fill), 0);
        halt = 1'b0;
        wait_rx(4);
        check("R9 rx_fill four", 32'(rx_fill), 4);
        check("R1 tx drained", 32'(tx_fill), 0);
        check("R10 no overflow yet", 32'(rx_overflow), 0);
        push(16'h66, 1'b0, 6'b000001);
        repeat (80) step();
        check("R10 rx_fill held", 32'(rx_fill), 4);
        check("R10 overflow set", 32'(rx_overflow), 1);
        check("R9 rx word 1", 32'(rx_data), 32'h11); pop();
        check("R9 rx word 2", 32'(rx_data), 32'h22); pop();
        check("R9 rx word 3", 32'(rx_data), 32'h33); pop();
        check("R1 fifth push dropped", 32'(rx_data), 32'h44); pop();
        check("R10 overflow sticky", 32'(rx_overflow), 1);
        flush_rx = 1'b1; step(); flush_rx = 1'b0;
        check("R11 flush clears overflow", 32'(rx_overflow), 0);

        // Continuous select with mixed idle levels
        cfg_cs_idle = 6'b101011;
        repeat (3) step();
        halt = 1'b1;
        push(16'hA1, 1'b1, 6'b000100);
        push(16'hB2, 1'b0, 6'b000100);
        begin
            int r0;
            r0 = release_cnt;
            halt = 1'b0;
            wait_rx(2);
            check("R6 one release for joined frames", release_cnt - r0, 1);
            check("R6 joined bit count", mon_cnt, 16);
            check("R6 joined wire data", mon_val, 32'h0000A1B2);
            check("R5 active select pattern", 32'(cs_pat), 32'h2F);
        end
        pop(); pop();
        halt = 1'b1;
        push(16'h5A, 1'b0, 6'b001000);
        push(16'hC3, 1'b0, 6'b001000);
        begin
            int r0;
            r0 = release_cnt;
            halt = 1'b0;
            wait_rx(2);
            check("R6 separate frames release twice", release_cnt - r0, 2);
            check("R5 active low line pattern", 32'(cs_pat), 32'h23);
        end
        pop(); pop();

        // Transmit flush, including flush with a simultaneous push
        halt = 1'b1;
        push(16'h01, 1'b0, 6'b000001);
        push(16'h02, 1'b0, 6'b000001);
        push(16'h03, 1'b0, 6'b000001);
        flush_tx = 1'b1; tx_push = 1'b1; tx_data = 16'h04; tx_sel = 6'b000001;
        step();
        flush_tx = 1'b0; tx_push = 1'b0;
        check("R11 tx flush beats push", 32'(tx_fill), 0);
        begin
            int r0;
            r0 = release_cnt;
            halt = 1'b0;
            repeat (60) step();
            check("R11 nothing sent after flush", release_cnt - r0, 0);
            check("R11 no rx after flush", 32'(rx_fill), 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule